// File: doc/BRIEF.md
# Low-order path V5 overhead monitor

This block watches a low-order virtual container path that arrives one byte per accepted clock. A strobe marks the path overhead byte that opens each four-frame multiframe. A second flag marks the pointer bytes that sit inside the stream and are not part of the container.

The block computes a two-bit interleaved parity over each multiframe. When the next overhead byte arrives, it compares that parity with the two parity bits the byte carries and adds every mismatched bit to a saturating error counter. The same byte also gives the far-end error indication, the failure indication, the defect indication and a three-bit signal label. These are held until the next overhead byte arrives, and the label is compared with a programmed expected value.

For the return direction, the block assembles an outgoing overhead byte from several sources:
- the parity of the last complete received multiframe;
- an error indication that is set when the last comparison found a mismatch;
- the local failure, defect and label inputs.

Top module: `v5_path_mon`

## Requirements
- R1: After reset, err_cnt is 0, err_pulse is 0, all rx_* outputs are 0, label_mm is 0, and v5_out bits 7:6 and bit 5 are 0.
- R2: Bit 1 of the overhead byte is in_byte[7]. Parity bit 1 is even parity over byte bits 1, 3, 5 and 7 (in_byte[7], [5], [3], [1]). Parity bit 2 is even parity over bits 2, 4, 6 and 8 (in_byte[6], [4], [2], [0]). The parity covers every accepted byte from one overhead byte up to, but not including, the next one, and the opening overhead byte is part of it. It is compared with in_byte[7:6] of the next overhead byte.
- R3: A byte with in_vld low has no effect, whatever its data, in_v5 and in_ptr. A byte accepted with in_ptr high and in_v5 low is excluded from the parity.
- R4: The first overhead byte after reset causes no comparison, so err_cnt and err_pulse are unchanged.
- R5: Each comparison adds its number of mismatched parity bits (0, 1 or 2) to err_cnt. err_cnt saturates at 2^CNT_W-1.
- R6: err_pulse is high for exactly the one cycle after an overhead byte whose comparison found at least one mismatch.
- R7: On each overhead byte the block captures four fields and holds them until the next overhead byte:
  - rx_rei from bit 3 (in_byte[5]);
  - rx_rfi from bit 4 (in_byte[4]);
  - rx_label from bits 5 to 7 (in_byte[3:1], bit 5 as the MSB);
  - rx_rdi from bit 8 (in_byte[0]).
- R8: label_mm is high when rx_label is neither 000 nor equal to exp_label.
- R9: v5_out is built as follows:
  - bits 7:6 hold the parity of the last complete received multiframe;
  - bit 5 is set when the last comparison found a mismatch;
  - bit 4 is tx_fail;
  - bits 3:1 are tx_label;
  - bit 0 is tx_ais.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Byte accepted this cycle |
| in_byte | input | 8 | Path byte, bit 1 in bit 7 |
| in_v5 | input | 1 | Byte is the multiframe overhead byte |
| in_ptr | input | 1 | Byte is a pointer byte, excluded from parity |
| exp_label | input | 3 | Expected signal label |
| tx_label | input | 3 | Label for the outgoing byte |
| tx_fail | input | 1 | Local failure declared |
| tx_ais | input | 1 | AIS or signal fail received locally |
| err_cnt | output | CNT_W | Saturating parity error count |
| err_pulse | output | 1 | One-cycle mismatch indication |
| rx_rei | output | 1 | Received far-end error indication |
| rx_rfi | output | 1 | Received failure indication |
| rx_rdi | output | 1 | Received defect indication |
| rx_label | output | 3 | Received signal label |
| label_mm | output | 1 | Label mismatch |
| v5_out | output | 8 | Outgoing overhead byte |

## Verification
The bench builds the block with CNT_W=3, so the counter ceiling is 7. That ceiling is reached after a handful of two-bit mismatches, which brings saturation and the pulse that fires at the ceiling within reach. The stream lengths are short and include pointer bytes and idle cycles that carry random data and random strobes. This shows that excluded and idle bytes leave the parity untouched, as seen in both the error count and the parity field of the outgoing byte.

// File: rtl/v5_pkg.sv
package v5_pkg;
  // bit positions inside the overhead byte (bit 1 of the byte = index 7)
  localparam int POS_REI = 5;
  localparam int POS_RFI = 4;
  localparam int POS_RDI = 0;
  localparam int LBL_LO  = 1;
  localparam int LBL_HI  = 3;

  // two interleaved even-parity bits of one byte
  function automatic logic [1:0] bip2_fold(input logic [7:0] b);
    return {b[7] ^ b[5] ^ b[3] ^ b[1], b[6] ^ b[4] ^ b[2] ^ b[0]};
  endfunction

  function automatic logic [1:0] mismatch_num(input logic [1:0] d);
    return {1'b0, d[1]} + {1'b0, d[0]};
  endfunction

  function automatic logic [7:0] pack_v5(input logic [1:0] bip, input logic rei,
                                         input logic rfi, input logic [2:0] lbl,
                                         input logic rdi);
    return {bip, rei, rfi, lbl, rdi};
  endfunction
endpackage

// File: rtl/v5_bip_chk.sv
module v5_bip_chk
  import v5_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       v5_evt,
  input  logic       cov_evt,
  input  logic [7:0] byte_in,
  output logic       cmp_vld,
  output logic [1:0] cmp_bits,
  output logic [1:0] last_bip,
  output logic       rei_flag
);
  logic [1:0] acc_q;
  logic       seen_q;
  logic [1:0] diff;

  assign diff     = byte_in[7:6] ^ acc_q;
  assign cmp_vld  = v5_evt & seen_q;
  assign cmp_bits = mismatch_num(diff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      seen_q   <= 1'b0;
      last_bip <= '0;
      rei_flag <= 1'b0;
    end else if (v5_evt) begin
      acc_q  <= bip2_fold(byte_in);
      seen_q <= 1'b1;
      if (seen_q) begin
        last_bip <= acc_q;
        rei_flag <= |diff;
      end
    end else if (cov_evt) begin
      acc_q <= acc_q ^ bip2_fold(byte_in);
    end
  end

  AST_SKIP_NO_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!v5_evt && !cov_evt) |=> $stable(acc_q)); // R3
  AST_BIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !v5_evt |=> ($stable(last_bip) && $stable(rei_flag))); // R9
endmodule

// File: rtl/v5_err_cnt.sv
module v5_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_vld,
  input  logic [1:0]       cmp_bits,
  output logic [CNT_W-1:0] err_cnt,
  output logic             err_pulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_nxt;
  logic [1:0]       add;

  assign add     = cmp_vld ? cmp_bits : 2'd0;
  assign sum     = {1'b0, err_cnt} + {{(CNT_W-1){1'b0}}, add};
  assign cnt_nxt = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_cnt   <= '0;
      err_pulse <= 1'b0;
    end else begin
      err_cnt   <= cnt_nxt;
      err_pulse <= cmp_vld && (cmp_bits != 2'd0);
    end
  end

  AST_CNT_NO_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt >= $past(err_cnt)); // R5
  AST_CNT_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == CNT_MAX) |=> (err_cnt == CNT_MAX)); // R5
  AST_PULSE_WITH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pulse && $past(err_cnt) != CNT_MAX) |-> (err_cnt != $past(err_cnt))); // R6
endmodule

// File: rtl/v5_field_rx.sv
module v5_field_rx
  import v5_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       v5_evt,
  input  logic [7:0] byte_in,
  input  logic [2:0] exp_label,
  output logic       rx_rei,
  output logic       rx_rfi,
  output logic       rx_rdi,
  output logic [2:0] rx_label,
  output logic       label_mm
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rei   <= 1'b0;
      rx_rfi   <= 1'b0;
      rx_rdi   <= 1'b0;
      rx_label <= '0;
    end else if (v5_evt) begin
      rx_rei   <= byte_in[POS_REI];
      rx_rfi   <= byte_in[POS_RFI];
      rx_rdi   <= byte_in[POS_RDI];
      rx_label <= byte_in[LBL_HI:LBL_LO];
    end
  end

  assign label_mm = (rx_label != 3'b000) && (rx_label != exp_label);

  always_comb begin
    if (rst_n) begin
      AST_MM_NONZERO: assert (!label_mm || rx_label != 3'b000); // R8
    end
  end

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !v5_evt |=> $stable({rx_rei, rx_rfi, rx_label, rx_rdi})); // R7
endmodule

// File: rtl/v5_path_mon.sv
module v5_path_mon
  import v5_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [7:0]       in_byte,
  input  logic             in_v5,
  input  logic             in_ptr,
  input  logic [2:0]       exp_label,
  input  logic [2:0]       tx_label,
  input  logic             tx_fail,
  input  logic             tx_ais,
  output logic [CNT_W-1:0] err_cnt,
  output logic             err_pulse,
  output logic             rx_rei,
  output logic             rx_rfi,
  output logic             rx_rdi,
  output logic [2:0]       rx_label,
  output logic             label_mm,
  output logic [7:0]       v5_out
);
  logic       v5_evt;
  logic       cov_evt;
  logic       cmp_vld;
  logic [1:0] cmp_bits;
  logic [1:0] last_bip;
  logic       rei_q;

  assign v5_evt  = in_vld & in_v5;
  assign cov_evt = in_vld & ~in_v5 & ~in_ptr;

  v5_bip_chk u_bip (
    .clk(clk), .rst_n(rst_n), .v5_evt(v5_evt), .cov_evt(cov_evt),
    .byte_in(in_byte), .cmp_vld(cmp_vld), .cmp_bits(cmp_bits),
    .last_bip(last_bip), .rei_flag(rei_q)
  );

  v5_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cmp_vld(cmp_vld), .cmp_bits(cmp_bits),
    .err_cnt(err_cnt), .err_pulse(err_pulse)
  );

  v5_field_rx u_rx (
    .clk(clk), .rst_n(rst_n), .v5_evt(v5_evt), .byte_in(in_byte),
    .exp_label(exp_label), .rx_rei(rx_rei), .rx_rfi(rx_rfi),
    .rx_rdi(rx_rdi), .rx_label(rx_label), .label_mm(label_mm)
  );

  assign v5_out = pack_v5(last_bip, rei_q, tx_fail, tx_label, tx_ais);

  // checker state: has any overhead byte been seen since reset
  logic chk_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_seen <= 1'b0;
    else if (v5_evt) chk_seen <= 1'b1;
  end

  AST_FIRST_NO_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    (v5_evt && !chk_seen) |=> (!err_pulse && $stable(err_cnt))); // R4
  AST_PULSE_AFTER_V5: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(v5_evt)); // R6
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse); // R6
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    !v5_evt |=> $stable(err_cnt)); // R3
endmodule

// File: tb/v5_path_mon_bench.sv
`timescale 1ns/1ps
module v5_path_mon_bench;
  localparam int CW = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, in_vld, in_v5, in_ptr, tx_fail, tx_ais;
  logic [7:0]    in_byte;
  logic [2:0]    exp_label, tx_label;
  logic [CW-1:0] err_cnt;
  logic          err_pulse, rx_rei, rx_rfi, rx_rdi, label_mm;
  logic [2:0]    rx_label;
  logic [7:0]    v5_out;

  v5_path_mon #(.CNT_W(CW)) u_v5_path_mon (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_byte(in_byte),
    .in_v5(in_v5), .in_ptr(in_ptr), .exp_label(exp_label),
    .tx_label(tx_label), .tx_fail(tx_fail), .tx_ais(tx_ais),
    .err_cnt(err_cnt), .err_pulse(err_pulse), .rx_rei(rx_rei),
    .rx_rfi(rx_rfi), .rx_rdi(rx_rdi), .rx_label(rx_label),
    .label_mm(label_mm), .v5_out(v5_out)
  );

  typedef struct packed {
    logic       first;
    logic [7:0] cnt;
    logic       pulse;
    logic       rei;
    logic       rfi;
    logic       rdi;
    logic [2:0] lbl;
    logic       mm;
    logic [7:0] v5o;
  } exp_t;

  exp_t exp_q[$];
  event chk_ev;
  int   checks = 0;
  int   errs   = 0;
  bit   finished = 1'b0;

  // reference model state
  bit [1:0] m_acc;
  bit       m_seen;
  int       m_cnt;
  bit [1:0] m_last;
  bit       m_rei;

  // parity by walking positions 1..8, odd positions feed the first bit
  function automatic bit [1:0] model_par(bit [7:0] b);
    bit [1:0] p = 2'b00;
    for (int pos = 1; pos <= 8; pos++) begin
      if (pos % 2 == 1) p[1] = p[1] ^ b[8 - pos];
      else              p[0] = p[0] ^ b[8 - pos];
    end
    return p;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(bit v, bit [7:0] b, bit s5, bit sp);
    @(negedge clk);
    in_vld = v; in_byte = b; in_v5 = s5; in_ptr = sp;
  endtask

  task automatic run_mf(bit [1:0] corrupt, bit [5:0] low6, bit gaps);
    bit [7:0] v5b;
    exp_t     e;
    int       nerr;
    v5b = {m_acc ^ corrupt, low6};
    drive(1'b1, v5b, 1'b1, 1'b0);
    e.first = !m_seen;
    e.pulse = 1'b0;
    if (m_seen) begin
      nerr = int'(corrupt[1]) + int'(corrupt[0]);
      m_cnt = (m_cnt + nerr > CMAX) ? CMAX : m_cnt + nerr;
      m_rei = (nerr != 0);
      e.pulse = (nerr != 0);
      m_last = m_acc;
    end
    m_acc  = model_par(v5b);
    m_seen = 1'b1;
    e.cnt = 8'(m_cnt);
    e.rei = low6[5]; e.rfi = low6[4]; e.lbl = low6[3:1]; e.rdi = low6[0];
    e.mm  = (low6[3:1] != 3'b000) && (low6[3:1] != exp_label);
    e.v5o = {m_last, m_rei, tx_fail, tx_label, tx_ais};
    @(negedge clk);
    exp_q.push_back(e);
    -> chk_ev;
    in_vld = 1'b0;
    for (int k = 0; k < 12; k++) begin
      bit [7:0] d = 8'($urandom);
      if (gaps && (k % 3 == 1))
        drive(1'b0, d, 1'($urandom), 1'($urandom));
      else if (k == 2 || k == 6 || k == 10)
        drive(1'b1, d, 1'b0, 1'b1);
      else begin
        drive(1'b1, d, 1'b0, 1'b0);
        m_acc = m_acc ^ model_par(d);
      end
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      exp_t e;
      @(chk_ev);
      e = exp_q.pop_front();
      check(e.first ? "R4 count unchanged" : "R5 count", int'(err_cnt), int'(e.cnt));
      check(e.first ? "R4 no pulse" : "R6 pulse", int'(err_pulse), int'(e.pulse));
      check("R7 rei", int'(rx_rei), int'(e.rei));
      check("R7 rfi", int'(rx_rfi), int'(e.rfi));
      check("R7 rdi", int'(rx_rdi), int'(e.rdi));
      check("R7 label", int'(rx_label), int'(e.lbl));
      check("R8 mismatch", int'(label_mm), int'(e.mm));
      check("R2 R3 outgoing parity", int'(v5_out[7:6]), int'(e.v5o[7:6]));
      check("R9 outgoing low bits", int'(v5_out[5:0]), int'(e.v5o[5:0]));
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_byte = '0; in_v5 = 1'b0; in_ptr = 1'b0;
    exp_label = 3'b101; tx_label = 3'b000; tx_fail = 1'b0; tx_ais = 1'b0;
    m_acc = '0; m_seen = 1'b0; m_cnt = 0; m_last = '0; m_rei = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 count", int'(err_cnt), 0);
    check("R1 pulse", int'(err_pulse), 0);
    check("R1 fields", int'({rx_rei, rx_rfi, rx_label, rx_rdi}), 0);
    check("R1 mismatch", int'(label_mm), 0);
    check("R1 outgoing", int'(v5_out), 0);
    tx_label = 3'b010;
    run_mf(2'b11, 6'b0_0_101_0, 1'b0);  // first after reset: ignored
    run_mf(2'b00, 6'b1_0_101_1, 1'b1);  // clean
    run_mf(2'b01, 6'b0_1_000_0, 1'b1);  // one bit, label 000
    tx_fail = 1'b1; tx_ais = 1'b1; tx_label = 3'b111;
    run_mf(2'b10, 6'b0_0_011_1, 1'b0);  // one bit, label differs
    run_mf(2'b11, 6'b1_1_101_0, 1'b1);  // two bits
    run_mf(2'b00, 6'b0_0_101_0, 1'b1);  // clean, error flag clears
    run_mf(2'b11, 6'b0_0_110_0, 1'b0);  // reaches 6
    run_mf(2'b11, 6'b0_0_101_0, 1'b1);  // saturates at 7
    run_mf(2'b01, 6'b0_0_101_0, 1'b0);  // stays 7, still pulses
    run_mf(2'b00, 6'b0_0_101_0, 1'b0);
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule